// File: doc/BRIEF.md
# Accelerator Command Queue

This block is the host-facing command queue of a graphics accelerator. The host reaches it over a narrow 16-bit register bus, so a 32-bit command goes in as two writes. The first write loads the upper half into a holding register. The second write supplies the lower half, and that write pushes the joined word into an on-chip FIFO. On the other side, the execution engine drains words through a valid/ready stream. It also reports, through a separate one-cycle strobe, each word whose execution has finished.

Software throttles itself by polling an outstanding-word count, which covers words that are queued and words that are executing. It may write n more words once that count is at most DEPTH minus n. A room register reports the same budget directly. Further registers give a flush control, an interrupt enable, and a write-one-to-clear status register holding a completion flag and a sticky overflow flag. The interrupt line follows the completion flag gated by the enable.

Register map (3-bit word address): 0 upper half (write), 1 lower half and commit (write), 2 outstanding count (read), 3 room (read), 4 size minus one (read), 5 flush (write, bit 0), 6 interrupt enable (read/write, bit 0), 7 status (read, write-one-to-clear; bit 0 completion, bit 1 overflow). Reads of write-only addresses return zero.

Top module: `acc_cmd_queue`

## Requirements
- R1: After reset the count reads 0, room reads DEPTH, status reads 0, enable reads 0, irqOut is low and outValid is low.
- R2: A write to address 1 pushes {upper half, written lower half}. outValid is high and outData carries that word in the cycle after the write's clock edge. The count rises by one on the same edge.
- R3: Words leave on outData in the order they were committed, and one word leaves per cycle in which outValid and outReady are both high.
- R4: The count falls by one only on a cycle with wordDone high. Taking a word over the stream leaves the count unchanged, and wordDone while the count is 0 changes nothing.
- R5: Room (address 3) always reads DEPTH minus the count, and address 4 reads DEPTH-1.
- R6: A commit write while the count equals DEPTH is dropped, and it sets status bit 1. That bit stays set until software writes 1 to it.
- R7: A write to address 5 with bit 0 set empties the FIFO (outValid low) and zeroes the count. With bit 0 clear, the write has no effect.
- R8: Status bit 0 is set by a counted wordDone and cleared by writing 1 to it. When both happen in the same cycle, the set wins.
- R9: irqOut is high exactly while status bit 0 and enable bit 0 are both set.
- R10: The upper-half register keeps its value across commits, so consecutive lower-half writes reuse the last upper half written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| outValid | output | 1 | Command word available |
| outReady | input | 1 | Engine takes the word |
| outData | output | 32 | Command word at FIFO head |
| wordDone | input | 1 | Engine finished executing one word |
| irqOut | output | 1 | Completion interrupt |

## Verification
Every registered result becomes visible one edge after its cause: the count, room, status, flush effect and head word after a write, and the count, status and irqOut after a wordDone pulse. Reads are combinational from those registers. The bench drives all inputs at the falling edge, so each stimulus is taken at the next rising edge, and it samples at the falling edge after that. A full-queue case fills all DEPTH slots, attempts one extra commit, and then drains the whole queue. This shows that the extra word never entered the queue and that draining leaves the count at DEPTH.

// File: rtl/acq_pkg.sv
package acq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic latchHi;
    logic push;
    logic flush;
  } dpStrobe_t;

  localparam logic [2:0] ADDR_HI    = 3'd0;
  localparam logic [2:0] ADDR_LO    = 3'd1;
  localparam logic [2:0] ADDR_COUNT = 3'd2;
  localparam logic [2:0] ADDR_ROOM  = 3'd3;
  localparam logic [2:0] ADDR_SIZE  = 3'd4;
  localparam logic [2:0] ADDR_FLUSH = 3'd5;
  localparam logic [2:0] ADDR_IRQEN = 3'd6;
  localparam logic [2:0] ADDR_STAT  = 3'd7;
endpackage

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [HW-1:0]   wrHalf,
  input  logic            outReady,
  output logic            outValid,
  output logic [2*HW-1:0] outData
);
  localparam int DW = 2 * HW;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [HW-1:0] hiHold;
  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [OW-1:0] occ;
  logic          pop;

  assign outValid = (occ != '0);
  assign pop      = outValid && outReady && !strobe.flush;
  assign outData  = store[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) hiHold <= '0;
    else if (strobe.latchHi) hiHold <= wrHalf;
  end

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= {hiHold, wrHalf};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (pop) rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // R3: occupancy never exceeds capacity
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OW'(DEPTH));
  // R7: flush leaves the stream empty
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> !outValid);
  // R2: a push into an empty queue appears next cycle
  p_push_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !outValid) |=> outValid);
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [2:0]    regAddr,
  input  logic [HW-1:0] regWrData,
  input  logic          wordDone,
  output logic [HW-1:0] regRdData,
  output dpStrobe_t     strobe,
  output logic          irqOut
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          irqEn, doneFlag, ovfFlag;
  logic          wrLo, pushOk, decOk, clrDone, clrOvf;

  assign wrLo    = regWrEn && (regAddr == ADDR_LO);
  assign pushOk  = wrLo && (count != CW'(DEPTH));
  assign decOk   = wordDone && (count != '0);
  assign clrDone = regWrEn && (regAddr == ADDR_STAT) && regWrData[0];
  assign clrOvf  = regWrEn && (regAddr == ADDR_STAT) && regWrData[1];

  assign strobe.latchHi = regWrEn && (regAddr == ADDR_HI);
  assign strobe.push    = pushOk;
  assign strobe.flush   = regWrEn && (regAddr == ADDR_FLUSH) && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) count <= '0;
    else begin
      case ({pushOk, decOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      doneFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_IRQEN) irqEn <= regWrData[0];
      if (decOk) doneFlag <= 1'b1;
      else if (clrDone) doneFlag <= 1'b0;
      if (wrLo && !pushOk) ovfFlag <= 1'b1;
      else if (clrOvf) ovfFlag <= 1'b0;
    end
  end

  assign irqOut = doneFlag && irqEn;

  always_comb begin
    case (regAddr)
      ADDR_COUNT: regRdData = HW'(count);
      ADDR_ROOM:  regRdData = HW'(CW'(DEPTH) - count);
      ADDR_SIZE:  regRdData = HW'(DEPTH - 1);
      ADDR_IRQEN: regRdData = {{(HW-1){1'b0}}, irqEn};
      ADDR_STAT:  regRdData = {{(HW-2){1'b0}}, ovfFlag, doneFlag};
      default:    regRdData = '0;
    endcase
  end

  // R6: a commit at full capacity is dropped and flagged
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && count == CW'(DEPTH)) |=> (ovfFlag && count == CW'(DEPTH)));
  // R4: a counted completion with nothing else lowers the count
  p_done_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && count != '0 && !regWrEn) |=> (count == $past(count) - 1'b1));
  // R7: flush zeroes the count
  p_flush_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (count == '0));
  // R9: completion with enable set raises the interrupt
  p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && count != '0 && irqEn && !(regWrEn && regAddr == ADDR_IRQEN))
      |=> irqOut);
  // R5: count bounded by capacity
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/acc_cmd_queue.sv
module acc_cmd_queue
  import acq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [2:0]      regAddr,
  input  logic [HW-1:0]   regWrData,
  output logic [HW-1:0]   regRdData,
  output logic            outValid,
  input  logic            outReady,
  output logic [2*HW-1:0] outData,
  input  logic            wordDone,
  output logic            irqOut
);
  dpStrobe_t strobe;

  acq_ctrl #(.DEPTH(DEPTH), .HW(HW)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .wordDone(wordDone), .regRdData(regRdData),
    .strobe(strobe), .irqOut(irqOut)
  );

  acq_datapath #(.DEPTH(DEPTH), .HW(HW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrHalf(regWrData),
    .outReady(outReady), .outValid(outValid), .outData(outData)
  );
endmodule

// File: tb/acc_cmd_queue_test.sv
module acc_cmd_queue_test;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outData;
  logic        wordDone = 1'b0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  acc_cmd_queue #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .wordDone(wordDone),
    .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic push(input logic [15:0] hi, input logic [15:0] lo);
    wr(3'd0, hi);
    wr(3'd1, lo);
  endtask

  task automatic done1();
    wordDone = 1'b1;
    @(negedge clk);
    wordDone = 1'b0;
  endtask

  task automatic expectCount(input int exp, input string tag);
    logic [15:0] v;
    rd(3'd2, v);
    chk(v == 16'(exp), tag, v, exp);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    expectCount(0, "R1 count");
    rd(3'd3, v); chk(v == 16'(DEPTH), "R1 room", v, DEPTH);
    rd(3'd7, v); chk(v == 0, "R1 status", v, 0);
    rd(3'd6, v); chk(v == 0, "R1 enable", v, 0);
    chk(!irqOut && !outValid, "R1 irq/valid", {irqOut, outValid}, 0);
  endtask

  task automatic t_single();
    logic [15:0] v;
    push(16'hABCD, 16'h1234);
    chk(outValid && outData == 32'hABCD1234, "R2 head word", outData, 32'hABCD1234);
    expectCount(1, "R2 count");
    rd(3'd3, v); chk(v == 16'(DEPTH - 1), "R5 room", v, DEPTH - 1);
    rd(3'd4, v); chk(v == 16'(DEPTH - 1), "R5 size", v, DEPTH - 1);
  endtask

  task automatic t_order();
    push(16'h0001, 16'h1111);
    push(16'h0002, 16'h2222);
    // R10: same upper half reused
    wr(3'd1, 16'h3333);
    expectCount(4, "R3 count after pushes");
    outReady = 1'b1;
    chk(outData == 32'hABCD1234, "R3 order 0", outData, 32'hABCD1234);
    @(negedge clk);
    chk(outData == 32'h00011111, "R3 order 1", outData, 32'h00011111);
    @(negedge clk);
    chk(outData == 32'h00022222, "R3 order 2", outData, 32'h00022222);
    @(negedge clk);
    chk(outData == 32'h00023333, "R10 held upper half", outData, 32'h00023333);
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid, "R3 drained", outValid, 0);
    expectCount(4, "R4 pop leaves count");
  endtask

  task automatic t_done_irq();
    logic [15:0] v;
    done1();
    expectCount(3, "R4 decrement");
    rd(3'd7, v); chk(v == 16'h1, "R8 status set", v, 1);
    chk(!irqOut, "R9 irq masked", irqOut, 0);
    wr(3'd6, 16'h1);
    chk(irqOut, "R9 irq enabled", irqOut, 1);
    wr(3'd7, 16'h0);
    rd(3'd7, v); chk(v == 16'h1, "R8 write 0 keeps", v, 1);
    wr(3'd7, 16'h1);
    rd(3'd7, v); chk(v == 16'h0, "R8 w1c", v, 0);
    chk(!irqOut, "R9 irq cleared", irqOut, 0);
    // set wins over clear in same cycle
    regWrEn = 1'b1; regAddr = 3'd7; regWrData = 16'h1; wordDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; wordDone = 1'b0;
    rd(3'd7, v); chk(v == 16'h1, "R8 set wins", v, 1);
    done1(); done1();
    expectCount(0, "R4 to zero");
    wr(3'd7, 16'h1);
    done1();
    expectCount(0, "R4 done at zero ignored");
    rd(3'd7, v); chk(v == 16'h0, "R4 no status at zero", v, 0);
    wr(3'd6, 16'h0);
  endtask

  task automatic t_flush();
    push(16'h5555, 16'h6666);
    push(16'h7777, 16'h8888);
    wr(3'd5, 16'h0);
    expectCount(2, "R7 flush bit0 clear ignored");
    chk(outValid && outData == 32'h55556666, "R7 head kept", outData, 32'h55556666);
    wr(3'd5, 16'h1);
    expectCount(0, "R7 flush count");
    chk(!outValid, "R7 flush empty", outValid, 1'b0);
  endtask

  task automatic t_full();
    logic [15:0] v;
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) push(16'(i), ~16'(i));
    rd(3'd3, v); chk(v == 0, "R5 room at full", v, 0);
    push(16'hDEAD, 16'hBEEF);
    expectCount(DEPTH, "R6 count at full");
    rd(3'd7, v); chk(v[1], "R6 overflow flag", v, 2);
    outReady = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (!outValid || outData != {16'(i), ~16'(i)}) bad++;
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(bad == 0, "R6 drained words intact", bad, 0);
    chk(!outValid, "R6 dropped word absent", outValid, 0);
    expectCount(DEPTH, "R4 drain keeps count");
    wr(3'd7, 16'h0);
    rd(3'd7, v); chk(v[1], "R6 sticky", v, 2);
    wr(3'd7, 16'h2);
    rd(3'd7, v); chk(!v[1], "R6 w1c", v, 0);
    wr(3'd5, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_done_irq();
    t_flush();
    t_full();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule